// File: doc/BRIEF.md
# Host Mailbox Bus Slave

This block is the host-facing side of a small I/O coprocessor. The host reaches it through one 8-bit Wishbone classic slave port that handles single reads and writes. The port's address space leads to three targets. The first is an outbound queue that the host fills and the coprocessor drains. The second is an inbound queue that the coprocessor fills and the host drains. The third is a window onto the host port of a shared register file, which sits outside this block.

Each queue has one writer and one reader, so neither queue needs arbitration. The coprocessor reaches the queues through plain push and pop strobes. A bus access that goes the wrong way for its target, or that would overflow or underflow a queue, still completes on the bus but changes nothing.

Top module: `wb_mailbox`

## Requirements
- R1: `ack_o` rises in the cycle after a strobe is accepted and stays high for exactly one cycle. A strobe seen while `ack_o` is high is not accepted, so a strobe held high is served once every two cycles.
- R2: A write to address 0x00 pushes `dat_i` into the 16-entry outbound queue. The coprocessor sees the entries on `cp_tx_data` in first-in first-out order, `cp_tx_valid` is high while the queue holds data, and `cp_tx_pop` removes the head.
- R3: A write to address 0x00 while the outbound queue is full is acknowledged but dropped. The queue contents and their order stay unchanged.
- R4: While `cp_rx_ready` is high, `cp_rx_push` stores `cp_rx_data` in the 16-entry inbound queue. A read of address 0x01 returns the oldest entry and removes it.
- R5: A read of address 0x01 while the inbound queue is empty is acknowledged, returns 0x00 and leaves the queue unchanged.
- R6: A read of address 0x02 returns the status byte: bit0 outbound full, bit1 outbound empty, bit2 inbound full, bit3 inbound empty, and bits 7:4 zero.
- R7: An access to addresses 0x80 to 0xFF reaches the register file at `rf_addr` = address bits 6:0. A write drives `rf_we` high for the accepting cycle, with `rf_wdata` = `dat_i`. A read returns the `rf_rdata` present in the accepting cycle.
- R8: A read of 0x00, a write to 0x01 or 0x02, and any access to 0x03 to 0x7F are acknowledged and have no effect. Such reads return 0x00.
- R9: A coprocessor pop of the empty outbound queue, and a coprocessor push into the full inbound queue, are ignored.
- R10: Synchronous reset empties both queues and clears `ack_o` and `dat_o`.
- R11: A host push to the outbound queue and a coprocessor pop from it in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Bus write enable |
| adr_i | input | 8 | Bus address |
| dat_i | input | 8 | Bus write data |
| ack_o | output | 1 | Bus acknowledge |
| dat_o | output | 8 | Bus read data |
| cp_tx_pop | input | 1 | Coprocessor removes the outbound head |
| cp_tx_data | output | 8 | Outbound queue head |
| cp_tx_valid | output | 1 | Outbound queue not empty |
| cp_rx_push | input | 1 | Coprocessor stores into the inbound queue |
| cp_rx_data | input | 8 | Inbound data from the coprocessor |
| cp_rx_ready | output | 1 | Inbound queue not full |
| rf_addr | output | 7 | Register file address |
| rf_we | output | 1 | Register file write strobe |
| rf_wdata | output | 8 | Register file write data |
| rf_rdata | input | 8 | Register file read data |

## Verification
A corrupted queue pointer or count shows up quickly at the ports. It appears either as a wrong value on `cp_tx_data` or on a host read of 0x01 at the next pop, or as a status byte with the wrong flags on the next read of 0x02. For that reason both queues are filled past capacity and then drained entry by entry, and each value is compared. A wrong handshake state shows on `ack_o` within one cycle of a strobe. A decode fault shows on the next read of the affected address, so every address in the map is swept.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [7:0] ADR_TX   = 8'h00;
  localparam logic [7:0] ADR_RX   = 8'h01;
  localparam logic [7:0] ADR_STAT = 8'h02;

  typedef enum logic [2:0] {
    TGT_TX, TGT_RX, TGT_STAT, TGT_RF, TGT_NONE
  } tgt_e;

  // status byte layout, lowest bit first: tx full, tx empty, rx full, rx empty
  function automatic logic [7:0] status_byte(input logic tx_full, input logic tx_empty,
                                             input logic rx_full, input logic rx_empty);
    return {4'b0000, rx_empty, rx_full, tx_empty, tx_full};
  endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_full_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (full && $stable(wr_ptr)));
  p_empty_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> (empty && $stable(rd_ptr)));
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
(
  input  logic [7:0] adr,
  output tgt_e       tgt
);
  always_comb begin
    if (adr[7])                tgt = TGT_RF;
    else if (adr == ADR_TX)    tgt = TGT_TX;
    else if (adr == ADR_RX)    tgt = TGT_RX;
    else if (adr == ADR_STAT)  tgt = TGT_STAT;
    else                       tgt = TGT_NONE;
  end
endmodule

// File: rtl/wb_mailbox.sv
module wb_mailbox
  import mbx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stb_i,
  input  logic       we_i,
  input  logic [7:0] adr_i,
  input  logic [7:0] dat_i,
  output logic       ack_o,
  output logic [7:0] dat_o,
  input  logic       cp_tx_pop,
  output logic [7:0] cp_tx_data,
  output logic       cp_tx_valid,
  input  logic       cp_rx_push,
  input  logic [7:0] cp_rx_data,
  output logic       cp_rx_ready,
  output logic [6:0] rf_addr,
  output logic       rf_we,
  output logic [7:0] rf_wdata,
  input  logic [7:0] rf_rdata
);
  tgt_e       tgt;
  logic       accept, wr_acc, rd_acc;
  logic       tx_push, rx_pop;
  logic       tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0] rx_dout, rd_val;

  mbx_decode u_dec (.adr(adr_i), .tgt(tgt));

  assign accept  = stb_i && !ack_o;
  assign wr_acc  = accept && we_i;
  assign rd_acc  = accept && !we_i;
  assign tx_push = wr_acc && (tgt == TGT_TX);
  assign rx_pop  = rd_acc && (tgt == TGT_RX);

  mbx_fifo #(.W(8), .DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst(rst), .push(tx_push), .din(dat_i), .pop(cp_tx_pop),
    .dout(cp_tx_data), .full(tx_full), .empty(tx_empty));

  mbx_fifo #(.W(8), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst(rst), .push(cp_rx_push), .din(cp_rx_data), .pop(rx_pop),
    .dout(rx_dout), .full(rx_full), .empty(rx_empty));

  assign cp_tx_valid = !tx_empty;
  assign cp_rx_ready = !rx_full;
  assign rf_addr     = adr_i[6:0];
  assign rf_wdata    = dat_i;
  assign rf_we       = wr_acc && (tgt == TGT_RF);

  always_comb begin
    case (tgt)
      TGT_RX:   rd_val = rx_empty ? 8'h00 : rx_dout;
      TGT_STAT: rd_val = status_byte(tx_full, tx_empty, rx_full, rx_empty);
      TGT_RF:   rd_val = rf_rdata;
      default:  rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o <= 1'b0;
      dat_o <= 8'h00;
    end else begin
      ack_o <= accept;
      if (accept) dat_o <= rd_acc ? rd_val : 8'h00;
    end
  end

  p_ack_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);
  p_ack_cause_r1: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(stb_i));
  p_empty_read_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && rx_empty) |=> (dat_o == 8'h00 && rx_empty));
  p_rf_write_window_r7: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (stb_i && we_i && adr_i[7] && !ack_o));
  p_no_stray_push_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && tgt != TGT_TX && !cp_tx_pop) |=> $stable(tx_empty) && $stable(tx_full));
endmodule

// File: tb/test_wb_mailbox.sv
module test_wb_mailbox;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stb_i = 1'b0, we_i = 1'b0;
  logic [7:0] adr_i = '0, dat_i = '0;
  logic       ack_o;
  logic [7:0] dat_o;
  logic       cp_tx_pop = 1'b0, cp_rx_push = 1'b0;
  logic [7:0] cp_tx_data, cp_rx_data = '0;
  logic       cp_tx_valid, cp_rx_ready;
  logic [6:0] rf_addr;
  logic       rf_we;
  logic [7:0] rf_wdata, rf_rdata;
  logic [7:0] rf_mem [128];

  int vectors = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  wb_mailbox i_wb_mailbox (
    .clk(clk), .rst(rst), .stb_i(stb_i), .we_i(we_i), .adr_i(adr_i), .dat_i(dat_i),
    .ack_o(ack_o), .dat_o(dat_o), .cp_tx_pop(cp_tx_pop), .cp_tx_data(cp_tx_data),
    .cp_tx_valid(cp_tx_valid), .cp_rx_push(cp_rx_push), .cp_rx_data(cp_rx_data),
    .cp_rx_ready(cp_rx_ready), .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .rf_rdata(rf_rdata));

  // register file model with combinational read
  assign rf_rdata = rf_mem[rf_addr];
  always @(posedge clk) if (rf_we) rf_mem[rf_addr] <= rf_wdata;

  function automatic logic [7:0] txv(input int i);  return 8'((i * 13) + 7);  endfunction
  function automatic logic [7:0] rxv(input int i);  return 8'((i * 41) ^ 8'hA5); endfunction
  function automatic logic [7:0] rfv(input int a);  return 8'((a * 29) + 3);  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [7:0] a, input logic [7:0] d,
                     output logic [7:0] r);
    @(negedge clk);
    stb_i = 1'b1; we_i = w; adr_i = a; dat_i = d;
    @(negedge clk);
    r = dat_o;
    check("R1 ack high", {7'b0, ack_o}, 8'h01);
    stb_i = 1'b0; we_i = 1'b0;
    @(negedge clk);
    check("R1 ack single", {7'b0, ack_o}, 8'h00);
  endtask

  task automatic cp_pop_expect(input string req, input logic [7:0] exp);
    @(negedge clk);
    check(req, cp_tx_data, exp);
    check({req, " valid"}, {7'b0, cp_tx_valid}, 8'h01);
    cp_tx_pop = 1'b1;
    @(negedge clk);
    cp_tx_pop = 1'b0;
  endtask

  task automatic cp_push(input logic [7:0] d);
    @(negedge clk);
    cp_rx_push = 1'b1; cp_rx_data = d;
    @(negedge clk);
    cp_rx_push = 1'b0;
  endtask

  initial begin
    logic [7:0] r;
    for (int a = 0; a < 128; a++) rf_mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 ack", {7'b0, ack_o}, 8'h00);
    check("R10 dat", dat_o, 8'h00);
    check("R10 tx valid", {7'b0, cp_tx_valid}, 8'h00);
    bus(1'b0, 8'h02, 8'h00, r); check("R6 status at reset", r, 8'h0A);

    // R2 / R3 outbound fill past capacity
    for (int i = 0; i < 16; i++) bus(1'b1, 8'h00, txv(i), r);
    bus(1'b0, 8'h02, 8'h00, r); check("R6 status tx full", r, 8'h09);
    bus(1'b1, 8'h00, 8'hEE, r);
    bus(1'b0, 8'h00, 8'h00, r); check("R8 read of push address", r, 8'h00);
    for (int i = 0; i < 16; i++) cp_pop_expect("R2 order R3 drop", txv(i));
    @(negedge clk); check("R3 no extra entry", {7'b0, cp_tx_valid}, 8'h00);
    cp_tx_pop = 1'b1; @(negedge clk); cp_tx_pop = 1'b0;   // R9 empty pop
    bus(1'b1, 8'h00, 8'h5A, r);
    cp_pop_expect("R9 after empty pop", 8'h5A);

    // R4 / R5 inbound
    for (int i = 0; i < 17; i++) cp_push(rxv(i));
    @(negedge clk); check("R9 rx ready when full", {7'b0, cp_rx_ready}, 8'h00);
    bus(1'b0, 8'h02, 8'h00, r); check("R6 status rx full", r, 8'h06);
    for (int i = 0; i < 16; i++) begin
      bus(1'b0, 8'h01, 8'h00, r); check("R4 rx order", r, rxv(i));
    end
    bus(1'b0, 8'h01, 8'h00, r); check("R5 empty read", r, 8'h00);
    bus(1'b0, 8'h02, 8'h00, r); check("R5 status after empty read", r, 8'h0A);

    // R7 register window sweep
    for (int a = 0; a < 128; a++) bus(1'b1, 8'(8'h80 + a), rfv(a), r);
    for (int a = 0; a < 128; a++) begin
      bus(1'b0, 8'(8'h80 + a), 8'h00, r); check("R7 rf readback", r, rfv(a));
    end

    // R8 unmapped and wrong-direction accesses
    for (int a = 3; a < 128; a++) begin
      bus(1'b1, 8'(a), 8'hFF, r);
      bus(1'b0, 8'(a), 8'h00, r); check("R8 unmapped read", r, 8'h00);
    end
    bus(1'b1, 8'h01, 8'h77, r);
    bus(1'b1, 8'h02, 8'h77, r);
    bus(1'b0, 8'h02, 8'h00, r); check("R8 status untouched", r, 8'h0A);
    bus(1'b0, 8'h01, 8'h00, r); check("R8 rx untouched", r, 8'h00);
    check("R8 rf untouched", rf_mem[0], rfv(0));

    // R1 strobe held through two transfers
    @(negedge clk); stb_i = 1'b1; we_i = 1'b1; adr_i = 8'h00; dat_i = 8'h11;
    @(negedge clk); check("R1 held ack1", {7'b0, ack_o}, 8'h01); dat_i = 8'h22;
    @(negedge clk); check("R1 held gap", {7'b0, ack_o}, 8'h00);
    @(negedge clk); check("R1 held ack2", {7'b0, ack_o}, 8'h01); stb_i = 1'b0; we_i = 1'b0;
    @(negedge clk); check("R1 held end", {7'b0, ack_o}, 8'h00);
    cp_pop_expect("R1 first held write", 8'h11);
    cp_pop_expect("R1 second held write", 8'h22);
    @(negedge clk); check("R1 exactly two accepts", {7'b0, cp_tx_valid}, 8'h00);

    // R11 simultaneous host push and coprocessor pop
    bus(1'b1, 8'h00, 8'h33, r);
    @(negedge clk); stb_i = 1'b1; we_i = 1'b1; adr_i = 8'h00; dat_i = 8'h44; cp_tx_pop = 1'b1;
    @(negedge clk); stb_i = 1'b0; we_i = 1'b0; cp_tx_pop = 1'b0;
    check("R11 ack", {7'b0, ack_o}, 8'h01);
    check("R11 head after swap", cp_tx_data, 8'h44);
    cp_pop_expect("R11 pop new entry", 8'h44);
    @(negedge clk); check("R11 empty", {7'b0, cp_tx_valid}, 8'h00);

    // R10 reset with both queues loaded
    bus(1'b1, 8'h00, 8'h99, r);
    cp_push(8'h98);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 tx cleared", {7'b0, cp_tx_valid}, 8'h00);
    bus(1'b0, 8'h02, 8'h00, r); check("R10 status cleared", r, 8'h0A);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule